// File: doc/BRIEF.md
# Parallel EEPROM Byte-Write Controller Model

This block is a clocked, synthesizable model of the control side of a 2048 x 8 parallel EEPROM. The chip-enable, output-enable and write-enable strobes, the 11-bit address and the write data arrive asynchronously. They are resynchronised to a system clock that is much faster than any strobe. The bidirectional data pins appear as a separate input, an output and an output-enable. The model holds the storage array and the address and data latches. It runs the self-timed byte program and reports progress by status polling on the data bus.

A byte write is framed by the period during which chip enable and write enable are both low while output enable is high. Either strobe may be the one that opens or closes the window. The address is taken when the window opens, which is the later of the two falling edges. The data is taken when the window closes, which is the earlier of the two rising edges. After that the internal cycle runs for a programmable number of clocks. During that time a read of the address being programmed returns the inverse of the new bit 7 with the low bits forced to zero. Other addresses read normally, and any new write attempt is discarded.

Top module: `eep_emul`

## Requirements
- R1: While reset is high and after it is released, `dq_oe` is 0 until a read is requested.
- R2: `dq_oe` is 1 only when chip enable is low, output enable is low and write enable is high. It is 0 when chip enable or output enable is high, and also when write enable is low.
- R3: With chip enable already low, a write-enable-controlled write stores its data at the address present when write enable falls. Address changes after that edge have no effect.
- R4: With write enable already low, a chip-enable-controlled write stores its data at the address present when chip enable falls. Address changes after that edge have no effect.
- R5: The stored byte is the data present just before the first rising edge of the write window. Data changes at or after that edge are not stored. A write fully replaces the previous contents of the byte.
- R6: For WRITE_CLKS clocks after a write window closes, a read of the address being programmed returns a byte whose bit 7 is the inverse of the new bit 7 and whose bits 6..0 are all 0.
- R7: During the internal cycle, reads of other addresses return their stored data. Once the cycle ends, a read of the programmed address returns the new byte on all eight bits.
- R8: A write window that opens while the internal cycle is busy changes no location.
- R9: No write occurs if output enable is low when the window would open. No write occurs if output enable goes low while chip enable and write enable are both still low; this aborts the window.
- R10: A write window that stays open for fewer than MIN_PULSE synchronised clocks changes no location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the strobes |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | 11 | Byte address |
| dq_in | input | 8 | Data from the external bus |
| dq_out | output | 8 | Data driven onto the external bus |
| dq_oe | output | 1 | Drive enable for dq_out; 0 means high impedance |

## Verification
Embedded properties check on every clock several structural rules. The array is written only as the busy period ends. The pending address and data stay frozen throughout that period. A commit follows only from a released window of at least MIN_PULSE clocks. The output enable is never raised after a cycle in which chip enable or output enable was high, and polling words always carry zero low bits. The bench scenarios are needed to show the edge-selection rules: which address and which data are captured when chip enable or write enable leads or trails. They also show that discarded strobes, aborted windows and glitches leave the stored bytes untouched, and that the polling word gives way to true data once the cycle ends.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam int ADDR_W = 11;
    localparam int DATA_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
    } pins_t;

    typedef struct packed {
        pins_t pins;
        addr_t addr;
        data_t data;
    } bus_t;

    localparam int BUS_W = $bits(bus_t);

    typedef enum logic [1:0] {
        WS_IDLE   = 2'd0,
        WS_STROBE = 2'd1,
        WS_BUSY   = 2'd2
    } wstate_e;

    function automatic logic window_open(pins_t p);
        return !p.ce_n && !p.we_n && p.oe_n;
    endfunction

    function automatic logic read_req(pins_t p);
        return !p.ce_n && !p.oe_n && p.we_n;
    endfunction

    function automatic data_t poll_word(data_t d);
        return {~d[DATA_W-1], {(DATA_W-1){1'b0}}};
    endfunction
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
    parameter int              W       = 8,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= RST_VAL;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= RST_VAL;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/eep_write_ctrl.sv
module eep_write_ctrl
    import eep_pkg::*;
#(
    parameter int WRITE_CLKS = 1000,
    parameter int MIN_PULSE  = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t pins,
    input  addr_t addr,
    input  data_t data,
    output logic  busy,
    output addr_t pend_addr,
    output data_t pend_data,
    output logic  mem_we
);
    localparam int TMR_W = (WRITE_CLKS > 1) ? $clog2(WRITE_CLKS) : 1;
    localparam int CNT_W = $clog2(MIN_PULSE + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WRITE_CLKS - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MIN_PULSE);

    wstate_e          state;
    logic [TMR_W-1:0] tmr;
    logic [CNT_W-1:0] cnt;
    logic             win, win_d, win_rise, released;

    assign win      = window_open(pins);
    assign win_rise = win && !win_d;
    assign released = pins.ce_n || pins.we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= WS_IDLE;
            tmr       <= '0;
            cnt       <= '0;
            win_d     <= 1'b0;
            pend_addr <= '0;
            pend_data <= '0;
        end else begin
            win_d <= win;
            unique case (state)
                WS_IDLE: begin
                    if (win_rise) begin
                        pend_addr <= addr;
                        pend_data <= data;
                        cnt       <= CNT_W'(1);
                        state     <= WS_STROBE;
                    end
                end
                WS_STROBE: begin
                    if (win) begin
                        pend_data <= data;
                        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                    end else if (released && cnt == CNT_MAX) begin
                        tmr   <= '0;
                        state <= WS_BUSY;
                    end else begin
                        state <= WS_IDLE;
                    end
                end
                WS_BUSY: begin
                    if (tmr == TMR_LAST) state <= WS_IDLE;
                    else                 tmr   <= tmr + 1'b1;
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

    assign busy   = (state == WS_BUSY);
    assign mem_we = busy && (tmr == TMR_LAST);

    // R7: program only as the busy period closes, then return to idle
    p_commit_at_end_r7: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (state == WS_IDLE));

    // R8: pending address and data are frozen for the whole busy period
    p_frozen_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(pend_addr) && $stable(pend_data)));

    // R8: busy never hands over directly to a new window
    p_no_strobe_from_busy_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> (state != WS_STROBE));

    // R10: a commit follows only a window held for MIN_PULSE clocks
    p_min_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(state) == WS_STROBE) |-> ($past(cnt) == CNT_MAX));

    // R9: a commit follows only a window released by CE or WE
    p_released_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(state) == WS_STROBE) |-> $past(released));

    initial begin
        a_params: assert (WRITE_CLKS >= 2 && MIN_PULSE >= 1);
    end
endmodule

// File: rtl/eep_emul.sv
module eep_emul
    import eep_pkg::*;
#(
    parameter int WRITE_CLKS  = 100000,
    parameter int MIN_PULSE   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic       we_n,
    input  logic [10:0] addr,
    input  logic [7:0] dq_in,
    output logic [7:0] dq_out,
    output logic       dq_oe
);
    localparam bus_t BUS_IDLE = '{pins: '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1},
                                  addr: '0, data: '0};

    bus_t  raw, syn;
    logic  busy, mem_we, rd, poll;
    addr_t pend_addr;
    data_t pend_data, arr_rd;
    data_t dout_q;
    logic  oe_q;

    assign raw = '{pins: '{ce_n: ce_n, oe_n: oe_n, we_n: we_n}, addr: addr, data: dq_in};

    eep_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn)
    );

    eep_write_ctrl #(.WRITE_CLKS(WRITE_CLKS), .MIN_PULSE(MIN_PULSE)) u_wctrl (
        .clk       (clk),
        .rst       (rst),
        .pins      (syn.pins),
        .addr      (syn.addr),
        .data      (syn.data),
        .busy      (busy),
        .pend_addr (pend_addr),
        .pend_data (pend_data),
        .mem_we    (mem_we)
    );

    eep_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (pend_addr),
        .wdata (pend_data),
        .raddr (syn.addr),
        .rdata (arr_rd)
    );

    assign rd   = read_req(syn.pins);
    assign poll = busy && (syn.addr == pend_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q   <= 1'b0;
            dout_q <= '0;
        end else begin
            oe_q   <= rd;
            dout_q <= poll ? poll_word(pend_data) : arr_rd;
        end
    end

    assign dq_out = dout_q;
    assign dq_oe  = oe_q;

    // R2: bus released one cycle after CE or OE is seen high
    p_hiz_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(syn.pins.ce_n) || $past(syn.pins.oe_n)) |-> !dq_oe);

    // R6: a polling word carries zero low bits and the inverted new bit 7
    p_poll_word_r6: assert property (@(posedge clk) disable iff (rst)
        $past(poll) |-> (dq_out[6:0] == 7'd0 && dq_out[7] == !$past(pend_data[7])));
endmodule

// File: tb/eep_emul_test.sv
module eep_emul_test;
    localparam int CLK_PERIOD = 10;
    localparam int WCLKS      = 40;
    localparam int MINP       = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0] dq_in = '0;
    logic [7:0] dq_out;
    logic       dq_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eep_emul #(.WRITE_CLKS(WCLKS), .MIN_PULSE(MINP), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // ce_mode=0: WE-controlled; ce_mode=1: CE-controlled
    task automatic strobe(input bit ce_mode, input logic [10:0] a0, a, a1,
                          input logic [7:0] d, d1, input logic oe_lvl, input int width);
        @(negedge clk);
        oe_n = oe_lvl; addr = a0; dq_in = d;
        if (ce_mode) we_n = 1'b0; else ce_n = 1'b0;
        clks(3);
        addr = a;
        if (ce_mode) ce_n = 1'b0; else we_n = 1'b0;
        clks(3);
        addr = a1;
        clks(width);
        if (ce_mode) ce_n = 1'b1; else we_n = 1'b1;
        dq_in = d1;
        clks(3);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        clks(2);
    endtask

    task automatic rd_chk(input string req, input logic [10:0] a, input logic [7:0] exp);
        @(negedge clk);
        addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        clks(5);
        chk(req, {dq_oe, dq_out}, {1'b1, exp});
        ce_n = 1'b1; oe_n = 1'b1;
        clks(2);
    endtask

    task automatic pins_chk(input string req, input logic c, o, w, input logic exp_oe);
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w; addr = 11'h010;
        clks(5);
        chk(req, {8'h00, dq_oe}, {8'h00, exp_oe});
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        clks(2);
    endtask

    task automatic wait_idle();
        clks(WCLKS + 10);
    endtask

    task automatic t_reset();
        clks(2);
        chk("R1 in reset", {8'h00, dq_oe}, 9'h000);
        @(negedge clk); rst = 1'b0;
        clks(4);
        chk("R1 after reset", {8'h00, dq_oe}, 9'h000);
    endtask

    task automatic t_baseline();
        strobe(1'b0, 11'h010, 11'h010, 11'h010, 8'h11, 8'h11, 1'b1, 8);
        wait_idle();
        strobe(1'b0, 11'h020, 11'h020, 11'h020, 8'h22, 8'h22, 1'b1, 8);
        wait_idle();
        rd_chk("R3 baseline", 11'h010, 8'h11);
        rd_chk("R3 baseline", 11'h020, 8'h22);
    endtask

    task automatic t_we_ctrl();
        strobe(1'b0, 11'h010, 11'h155, 11'h020, 8'h5A, 8'hFF, 1'b1, 8);
        wait_idle();
        rd_chk("R3 WE-ctrl target", 11'h155, 8'h5A);
        rd_chk("R3 address before WE fall untouched", 11'h010, 8'h11);
        rd_chk("R3 address after WE fall untouched", 11'h020, 8'h22);
    endtask

    task automatic t_ce_ctrl();
        strobe(1'b1, 11'h010, 11'h2AA, 11'h020, 8'hC3, 8'h3C, 1'b1, 8);
        wait_idle();
        rd_chk("R4 CE-ctrl target", 11'h2AA, 8'hC3);
        rd_chk("R4 address after CE fall untouched", 11'h020, 8'h22);
        rd_chk("R5 data before first rise", 11'h155, 8'h5A);
    endtask

    task automatic t_poll();
        strobe(1'b0, 11'h301, 11'h301, 11'h301, 8'h7E, 8'h7E, 1'b1, 8);
        rd_chk("R6 polling word", 11'h301, 8'h80);
        rd_chk("R7 other address during busy", 11'h155, 8'h5A);
        wait_idle();
        rd_chk("R7 true data after cycle", 11'h301, 8'h7E);
        strobe(1'b1, 11'h300, 11'h300, 11'h300, 8'h81, 8'h81, 1'b1, 8);
        rd_chk("R6 polling word bit7 set", 11'h300, 8'h00);
        wait_idle();
        rd_chk("R7 true data after cycle", 11'h300, 8'h81);
    endtask

    task automatic t_busy_ignore();
        strobe(1'b0, 11'h040, 11'h040, 11'h040, 8'h44, 8'h44, 1'b1, 8);
        strobe(1'b0, 11'h010, 11'h010, 11'h010, 8'hEE, 8'hEE, 1'b1, 8);
        wait_idle();
        rd_chk("R8 first write kept", 11'h040, 8'h44);
        rd_chk("R8 strobe during busy ignored", 11'h010, 8'h11);
    endtask

    task automatic t_inhibit();
        strobe(1'b0, 11'h010, 11'h010, 11'h010, 8'hAB, 8'hAB, 1'b0, 8);
        wait_idle();
        rd_chk("R9 OE low inhibits", 11'h010, 8'h11);
        // abort: OE drops while CE and WE are still low
        @(negedge clk);
        addr = 11'h020; dq_in = 8'h00; ce_n = 1'b0;
        clks(3);
        we_n = 1'b0;
        clks(8);
        oe_n = 1'b0;
        clks(3);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        wait_idle();
        rd_chk("R9 OE drop aborts", 11'h020, 8'h22);
    endtask

    task automatic t_glitch();
        @(negedge clk);
        addr = 11'h020; dq_in = 8'h77; ce_n = 1'b0;
        clks(3);
        we_n = 1'b0;
        clks(1);
        we_n = 1'b1;
        clks(3);
        ce_n = 1'b1;
        wait_idle();
        rd_chk("R10 short pulse ignored", 11'h020, 8'h22);
    endtask

    task automatic t_bus_ctrl();
        pins_chk("R2 OE high", 1'b0, 1'b1, 1'b1, 1'b0);
        pins_chk("R2 CE high", 1'b1, 1'b0, 1'b1, 1'b0);
        pins_chk("R2 WE low", 1'b0, 1'b0, 1'b0, 1'b0);
        pins_chk("R2 read drives", 1'b0, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_overwrite();
        strobe(1'b0, 11'h155, 11'h155, 11'h155, 8'h00, 8'h00, 1'b1, 8);
        wait_idle();
        rd_chk("R5 full replace", 11'h155, 8'h00);
    endtask

    initial begin
        t_reset();
        t_baseline();
        t_we_ctrl();
        t_ce_ctrl();
        t_poll();
        t_busy_ignore();
        t_inhibit();
        t_glitch();
        t_bus_ctrl();
        t_overwrite();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule